// File: doc/BRIEF.md
# Guarded Sequential FIR Engine

This block computes a short block of FIR filter outputs with one multiplier and one accumulator, which it reuses tap by tap. A host first fills a small local memory with input samples and filter coefficients through a plain write port. It then pulses `start`. The engine steps through every output position. For each position it fetches one sample and one coefficient per tap, accumulates their product and stores the finished sum back into a result region of the same memory. When the last result has been written, it raises `done` for one cycle. The host then reads the results through a registered read port.

Every tap carries a guard. The engine adds the sample and the coefficient and compares that sum against a fixed limit. A pair whose sum reaches the limit aborts the current output: the engine abandons its remaining taps, stores zero for that output and moves to the next position.

The memory map is fixed by parameters. With the defaults there are 16 samples at addresses 0 to 15, 8 coefficients at addresses 16 to 23, and 16 results at addresses 24 to 39. Each memory word is 20 bits wide.

Top module: `guarded_fir_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are both low.
- R2: A `start` pulse seen while idle begins a computation, and `busy` is high from the next cycle until the run ends.
- R3: Result n (n = 0 to 15) is written to address 24+n. Its value is the sum over k = 0 to 7 of coef[k] × sample[(n+k) mod 16]. Sample j is read from address j and coef[k] from address 16+k.
- R4: A tap product is accumulated only when sample + coefficient is strictly below 16. A sum of exactly 15 still counts.
- R5: If any tap of an output has sample + coefficient of 16 or more, that output is stored as zero.
- R6: The accumulator starts from zero for every output, so no result carries any part of another.
- R7: Only bits [7:0] of a sample or coefficient word are used, as unsigned values. Bits [19:8] do not affect any result.
- R8: `done` is high for exactly one cycle, after the sixteenth result has been written. `busy` is already low in that cycle.
- R9: A `start` pulse that arrives while `busy` is high is ignored: the run neither restarts nor produces a second `done`.
- R10: Host writes presented while `busy` is high do not change the memory.
- R11: `rd_data` returns the word stored at `rd_addr` one clock after the address is presented, while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Host write strobe into local memory |
| ld_addr | input | 6 | Host write address |
| ld_data | input | 20 | Host write data |
| rd_addr | input | 6 | Host read address |
| rd_data | output | 20 | Registered read data, one cycle after `rd_addr` |
| start | input | 1 | Begin a computation when idle |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse after the last result is stored |

## Verification
The assertions assume that `start` and the host strobes change only between clock edges. They also assume that the default map leaves the wrapped sample index below twice the sample count, so one subtraction always brings it back into range. The result-region and single-pulse properties hold only if the host never asks for a second run before `done`. The bench drives every input on the falling edge and finishes all loads before it pulses `start`. It breaks the idle-only rule on purpose in just one run: it raises a load strobe and a second `start` in the middle of the run, then checks that the results match the data loaded before the run.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FETCH,
    ST_ACC,
    ST_WRITE
  } fir_state_e;
endpackage

// File: rtl/fir_mem.sv
module fir_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    ra_data <= store[ra_addr];
  end

  always_ff @(posedge clk) begin
    rb_data <= store[rb_addr];
  end
endmodule

// File: rtl/fir_guard_mac.sv
module fir_guard_mac #(
  parameter int SAMPLE_W    = 8,
  parameter int ACC_W       = 20,
  parameter int GUARD_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             eval,
  input  logic [ACC_W-1:0] x_word,
  input  logic [ACC_W-1:0] h_word,
  output logic             pass,
  output logic [ACC_W-1:0] acc
);
  localparam int SUM_W  = SAMPLE_W + 1;
  localparam int PROD_W = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] x_val;
  logic [SAMPLE_W-1:0] h_val;
  logic [SUM_W-1:0]    pair_sum;
  logic [PROD_W-1:0]   prod;

  assign x_val    = x_word[SAMPLE_W-1:0];
  assign h_val    = h_word[SAMPLE_W-1:0];
  assign pair_sum = {1'b0, x_val} + {1'b0, h_val};
  assign pass     = (pair_sum < SUM_W'(GUARD_LIMIT));
  assign prod     = x_val * h_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (eval && pass) begin
      acc <= acc + ACC_W'(prod);
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0)); // R6
  AST_BLOCKED_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (eval && !pass && !clr) |=> $stable(acc)); // R4
endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_SAMPLES = 16,
  parameter int NUM_TAPS    = 8,
  parameter int NUM_OUT     = 16,
  parameter int COEF_BASE   = 16,
  parameter int OUT_BASE    = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tap_pass,
  output logic              busy,
  output logic              done,
  output logic              acc_clr,
  output logic              acc_eval,
  output logic [ADDR_W-1:0] samp_addr,
  output logic [ADDR_W-1:0] coef_addr,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              wr_zero
);
  localparam int OUT_W = $clog2(NUM_OUT);
  localparam int TAP_W = $clog2(NUM_TAPS);
  localparam int SUM_W = $clog2(NUM_OUT + NUM_TAPS) + 1;

  fir_state_e       state_q;
  logic [OUT_W-1:0] out_q;
  logic [TAP_W-1:0] tap_q;
  logic             fail_q;
  logic             done_q;
  logic [SUM_W-1:0] sidx_raw;
  logic [SUM_W-1:0] sidx;
  logic             last_tap;
  logic             last_out;

  assign last_tap = (tap_q == TAP_W'(NUM_TAPS - 1));
  assign last_out = (out_q == OUT_W'(NUM_OUT - 1));

  assign sidx_raw = SUM_W'(out_q) + SUM_W'(tap_q);
  assign sidx     = (sidx_raw >= SUM_W'(NUM_SAMPLES)) ? sidx_raw - SUM_W'(NUM_SAMPLES) : sidx_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      out_q   <= '0;
      tap_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            out_q   <= '0;
            state_q <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          tap_q   <= '0;
          fail_q  <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          if (!tap_pass) begin
            fail_q  <= 1'b1;
            state_q <= ST_WRITE;
          end else if (last_tap) begin
            state_q <= ST_WRITE;
          end else begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_WRITE: begin
          if (last_out) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            out_q   <= out_q + 1'b1;
            state_q <= ST_CLEAR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign acc_clr   = (state_q == ST_CLEAR);
  assign acc_eval  = (state_q == ST_ACC);
  assign eng_we    = (state_q == ST_WRITE);
  assign wr_zero   = fail_q;
  assign samp_addr = ADDR_W'(sidx);
  assign coef_addr = ADDR_W'(COEF_BASE) + ADDR_W'(tap_q);
  assign eng_addr  = ADDR_W'(OUT_BASE) + ADDR_W'(out_q);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
  AST_FAIL_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_eval && !tap_pass) |=> (eng_we && wr_zero)); // R5
  AST_WRITE_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> (eng_addr >= ADDR_W'(OUT_BASE) && eng_addr < ADDR_W'(OUT_BASE + NUM_OUT))); // R3
  AST_SAMPLE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    acc_eval |-> (samp_addr < ADDR_W'(NUM_SAMPLES))); // R3
endmodule

// File: rtl/guarded_fir_engine.sv
module guarded_fir_engine #(
  parameter int ADDR_W      = 6,
  parameter int ACC_W       = 20,
  parameter int SAMPLE_W    = 8,
  parameter int NUM_SAMPLES = 16,
  parameter int NUM_TAPS    = 8,
  parameter int NUM_OUT     = 16,
  parameter int COEF_BASE   = 16,
  parameter int OUT_BASE    = 24,
  parameter int GUARD_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ACC_W-1:0]  ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ACC_W-1:0]  rd_data,
  input  logic              start,
  output logic              busy,
  output logic              done
);
  logic              acc_clr;
  logic              acc_eval;
  logic              tap_pass;
  logic [ADDR_W-1:0] samp_addr;
  logic [ADDR_W-1:0] coef_addr;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic              wr_zero;
  logic [ACC_W-1:0]  acc;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ACC_W-1:0]  mem_wdata;
  logic [ADDR_W-1:0] ra_addr;
  logic [ACC_W-1:0]  ra_data;
  logic [ACC_W-1:0]  rb_data;

  fir_seq #(
    .ADDR_W      (ADDR_W),
    .NUM_SAMPLES (NUM_SAMPLES),
    .NUM_TAPS    (NUM_TAPS),
    .NUM_OUT     (NUM_OUT),
    .COEF_BASE   (COEF_BASE),
    .OUT_BASE    (OUT_BASE)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tap_pass  (tap_pass),
    .busy      (busy),
    .done      (done),
    .acc_clr   (acc_clr),
    .acc_eval  (acc_eval),
    .samp_addr (samp_addr),
    .coef_addr (coef_addr),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .wr_zero   (wr_zero)
  );

  fir_guard_mac #(
    .SAMPLE_W    (SAMPLE_W),
    .ACC_W       (ACC_W),
    .GUARD_LIMIT (GUARD_LIMIT)
  ) mac_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (acc_clr),
    .eval   (acc_eval),
    .x_word (ra_data),
    .h_word (rb_data),
    .pass   (tap_pass),
    .acc    (acc)
  );

  // The engine owns the write port and read port A while a run is active.
  assign mem_we    = busy ? eng_we : ld_we;
  assign mem_waddr = busy ? eng_addr : ld_addr;
  assign mem_wdata = busy ? (wr_zero ? '0 : acc) : ld_data;
  assign ra_addr   = busy ? samp_addr : rd_addr;

  fir_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (ACC_W)
  ) mem_i (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (coef_addr),
    .rb_data (rb_data)
  );

  assign rd_data = ra_data;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done)); // R1
endmodule

// File: tb/guarded_fir_engine_tb_top.sv
`timescale 1ns/1ps
module guarded_fir_engine_tb_top;
  localparam int AW = 6;
  localparam int DW = 20;
  localparam int NS = 16;
  localparam int NT = 8;
  localparam int NO = 16;
  localparam int CB = 16;
  localparam int OB = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          start = 1'b0;
  logic          busy;
  logic          done;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic [DW-1:0] s_w [NS];
  logic [DW-1:0] c_w [NT];

  always #2 clk = ~clk;

  guarded_fir_engine dut_i (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (ld_we),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .start   (start),
    .busy    (busy),
    .done    (done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input int n);
    logic [DW-1:0] sum = '0;
    for (int k = 0; k < NT; k++) begin
      int x = int'(s_w[(n + k) % NS][7:0]);
      int h = int'(c_w[k][7:0]);
      if (x + h >= 16) return '0;
      sum = sum + DW'(x * h);
    end
    return sum;
  endfunction

  task automatic host_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    ld_we = 1'b1;
    ld_addr = AW'(addr);
    ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic host_read(input int addr, output logic [DW-1:0] data);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(negedge clk);
    data = rd_data;
  endtask

  task automatic load_all();
    for (int i = 0; i < NS; i++) host_write(i, s_w[i]);
    for (int k = 0; k < NT; k++) host_write(CB + k, c_w[k]);
  endtask

  // Runs one computation; interfere=1 injects a host write and a second start mid-run.
  task automatic run_and_check(input string tag, input bit interfere);
    int wait_cnt = 0;
    int extra_done = 0;
    logic [DW-1:0] got;
    load_all();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {19'd0, busy}, 20'd1);
    if (interfere) begin
      repeat (40) @(negedge clk);
      ld_we = 1'b1;
      ld_addr = AW'(15);
      ld_data = 20'h00001;
      start = 1'b1;
      @(negedge clk);
      ld_we = 1'b0;
      start = 1'b0;
    end
    while (!done && wait_cnt < 2000) begin
      @(negedge clk);
      wait_cnt++;
    end
    check("R8 done seen", {19'd0, done}, 20'd1);
    check("R8 idle at done", {19'd0, busy}, 20'd0);
    @(negedge clk);
    check("R8 done one cycle", {19'd0, done}, 20'd0);
    if (interfere) begin
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (done || busy) extra_done++;
      end
      check("R9 no restart", DW'(extra_done), 20'd0);
      host_read(15, got);
      check("R10 sample unchanged", got, s_w[15]);
    end
    for (int n = 0; n < NO; n++) begin
      host_read(OB + n, got);
      $display("  %s out[%0d]=%0h", tag, n, got);
      check({tag, " R3 R6 R11 result"}, got, model(n));
    end
  endtask

  initial begin
    logic [DW-1:0] got;
    logic [31:0] lcg;
    repeat (4) @(negedge clk);
    check("R1 busy in reset", {19'd0, busy}, 20'd0);
    check("R1 done in reset", {19'd0, done}, 20'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", {19'd0, busy}, 20'd0);
    check("R1 done after reset", {19'd0, done}, 20'd0);

    // Case A: all pairs pass, several sums exactly 15 (R4 boundary)
    for (int i = 0; i < NS; i++) s_w[i] = DW'(i % 8);
    for (int k = 0; k < NT; k++) c_w[k] = DW'(k + 1);
    run_and_check("R4 caseA", 1'b0);
    check("R4 caseA out0 value", model(0), 20'd168);

    // Case B: one pair sums to exactly 16 for outputs 0 and 8 (R5)
    c_w[7] = 20'd9;
    run_and_check("R5 caseB", 1'b0);
    host_read(OB + 0, got);
    check("R5 out0 zero", got, 20'd0);
    host_read(OB + 8, got);
    check("R5 out8 zero", got, 20'd0);

    // Case C: upper bits filled with junk, same low bytes as case A (R7)
    for (int i = 0; i < NS; i++) s_w[i] = DW'(32'hA5A00 | (i % 8));
    for (int k = 0; k < NT; k++) c_w[k] = DW'(32'h3C300 | (k + 1));
    run_and_check("R7 caseC", 1'b0);
    host_read(OB + 0, got);
    check("R7 junk ignored", got, 20'd168);

    // Case D: pseudo-random small values, mix of passing and failing outputs
    lcg = 32'h1234_5678;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NS; i++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        s_w[i] = DW'((lcg >> 16) % (8 + r));
      end
      for (int k = 0; k < NT; k++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        c_w[k] = DW'((lcg >> 16) % (8 + r));
      end
      run_and_check("R3 R4 R5 caseD", 1'b0);
    end

    // Case E: host write and second start during a run (R9, R10)
    for (int i = 0; i < NS; i++) s_w[i] = DW'((i * 3) % 9);
    for (int k = 0; k < NT; k++) c_w[k] = DW'(6 - (k % 5));
    run_and_check("R9 R10 caseE", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule